// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block turns host-side configuration accesses into standard configuration-cycle addresses. Software first writes a 32-bit index word into an index register. It then reads or writes through a 4 KB little-endian data window. Each data-window access is combined with the stored index word and leaves the block, one cycle later, as a translated configuration request. That request carries an enable/bus/device/function/register address, the access direction and byte enables. A valid/ready handshake moves each request downstream.

Three index layouts are accepted:
- An index word with its top bit set is passed through almost unchanged.
- An index word with a nonzero two-bit type code in its lowest bits is treated as a type-1 style address.
- Any other index word carries a one-hot slot select in its upper bits. A trailing-zero priority encoder decodes that select, and the address is rebuilt in the conventional layout.

A small combinational swizzle is also included. It maps a device's interrupt pin to one of four shared interrupt lines and to the interrupt-controller input number that line drives.

Top module: `cfgx_translator`

## Requirements
- R1: After a synchronous active-low reset, `cfg_valid` is 0 and the stored index word is 0. A first access at offset 0 therefore yields address 0x8000F800.
- R2: When bit 31 of the stored index is 1, `cfg_addr` equals the index ORed with `acc_offset[1:0]` in bits 1:0.
- R3: When bit 31 is 0 and index bits 1:0 are nonzero, `cfg_addr` is the index with bits 2:0 replaced by `acc_offset[2:0]`.
- R4: Otherwise the device number is the position of the lowest set bit among index bits 30:11, counted from bit 0 (bit 11 gives device 11). Higher set bits are ignored.
- R5: When none of index bits 31:11 is set in the slot layout, the device number is 31.
- R6: In the slot layout, `cfg_addr` has:
  - bit 31 set;
  - bits 30:16 zero;
  - the device number in bits 15:11;
  - index bits 10:8 (function) in bits 10:8;
  - index bits 7:3 in bits 7:3;
  - `acc_offset[2:0]` in bits 2:0.
- R7: `cfg_be` is a base mask shifted left by `acc_offset[1:0]` and truncated to 4 bits. The base mask is 0001 when `acc_size` is 0 (byte), 0011 when it is 1 (halfword), and 1111 when it is 2 or 3 (word).
- R8: An access accepted at a clock edge (`acc_valid` and `acc_ready` both high) appears on the outputs after that edge. At that point `cfg_valid` is 1 and `cfg_write` equals `acc_write`.
- R9: While `cfg_valid` is 1 and `cfg_ready` is 0, `acc_ready` is 0 and the outputs hold their values. A pending new access does not disturb them.
- R10: `irq_line` equals (`irq_pin` + `irq_devfn[7:3]`) modulo 4.
- R11: `irq_vector` equals 0x1B + `irq_line`, so lines 0 to 3 map to inputs 0x1B to 0x1E.
- R12: A write through `idx_wr` replaces the whole stored index. Every later access uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| idx_wr | input | 1 | Index register write strobe |
| idx_wdata | input | 32 | Index word to store |
| acc_valid | input | 1 | Data-window access request |
| acc_ready | output | 1 | Access can be accepted this cycle |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_offset | input | 12 | Byte offset inside the data window |
| acc_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| cfg_valid | output | 1 | Translated request is valid |
| cfg_ready | input | 1 | Downstream takes the request |
| cfg_addr | output | 32 | Translated configuration address |
| cfg_be | output | 4 | Byte enables |
| cfg_write | output | 1 | Direction of the translated request |
| irq_devfn | input | 8 | Device/function number of the interrupting device |
| irq_pin | input | 2 | Interrupt pin index of that device (0..3) |
| irq_line | output | 2 | Shared interrupt line chosen |
| irq_vector | output | 8 | Interrupt-controller input number for that line |

## Verification
The bench targets the corner cases below; each wrong design would show a distinct symptom:
- An index with several upper bits set: a priority encoder that picked the highest bit would send the cycle to the wrong device.
- An index with no upper bit set: a design that defaulted to zero would address device 0 instead of the absent device 31.
- A type-1 index whose low bits collide with the access offset: if the formats were told apart by the wrong bits, the low address bits would be ORed instead of replaced.
- Halfword and word accesses at unaligned offsets: a missing truncation would show up in the byte enables.
- A request held under backpressure while a second one waits: a broken hold would overwrite the first request.

Interrupt swizzling is swept over every pin and a range of slot numbers, so that the modulo-4 wrap and the controller base number are both exercised.

// File: rtl/cfgx_pkg.sv
// Shared types and helpers for the configuration address translator.
// Assumes a 32-bit configuration address and 4 byte lanes.
package cfgx_pkg;

    localparam int CFG_AW   = 32;
    localparam int CFG_BE_W = 4;

    typedef enum logic [1:0] {
        FMT_RAW   = 2'd0,
        FMT_TYPE1 = 2'd1,
        FMT_SLOT  = 2'd2
    } cfg_fmt_e;

    // Byte-lane mask for an access of the given size at the given lane
    function automatic logic [CFG_BE_W-1:0] lane_mask(input logic [1:0] size,
                                                      input logic [1:0] lane);
        logic [CFG_BE_W-1:0] base;
        case (size)
            2'd0:    base = 4'b0001;
            2'd1:    base = 4'b0011;
            default: base = 4'b1111;
        endcase
        return CFG_BE_W'(base << lane);
    endfunction

endpackage

// File: rtl/cfgx_tz_enc.sv
// Trailing-zero priority encoder: reports the position of the lowest set
// bit of vec, and whether any bit is set. Purely combinational.
module cfgx_tz_enc #(
    parameter int W     = 21,
    localparam int PW   = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic [PW-1:0] pos,
    output logic          found
);

    // Scan from the top so the lowest set bit wins the last assignment
    always_comb begin
        pos   = '0;
        found = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                pos   = PW'(i);
                found = 1'b1;
            end
        end
    end

    // Reported bit is set and nothing below it is set
    always_comb begin
        if (found) begin
            assert_lowest_wins_R4: assert (vec[pos] &&
                ((vec & ((W'(1) << pos) - W'(1))) == '0));
        end
    end

endmodule

// File: rtl/cfgx_addr_fmt.sv
// Combines a stored index word with the low bits of a data-window offset.
// Selects one of three index layouts; the slot layout is rebuilt as
// enable / bus 0 / device / function / register. Combinational.
module cfgx_addr_fmt
    import cfgx_pkg::*;
#(
    parameter int OFF_W   = 12,
    parameter int SLOT_LO = 11,
    localparam int SEL_W  = CFG_AW - SLOT_LO,
    localparam int POS_W  = (SEL_W > 1) ? $clog2(SEL_W) : 1
) (
    input  logic [CFG_AW-1:0] idx,
    input  logic [OFF_W-1:0]  off,
    output logic [CFG_AW-1:0] addr,
    output cfg_fmt_e          fmt
);

    logic [POS_W-1:0] sel_pos;
    logic             sel_found;
    logic [4:0]       slot;

    cfgx_tz_enc #(.W(SEL_W)) u_enc (
        .vec   (idx[CFG_AW-1:SLOT_LO]),
        .pos   (sel_pos),
        .found (sel_found)
    );

    // Absolute bit position of the slot select; absent select gives 31
    always_comb begin
        slot = sel_found ? 5'(32'(sel_pos) + SLOT_LO) : 5'h1F;
    end

    // Pick the layout from the index word
    always_comb begin
        if (idx[31])               fmt = FMT_RAW;
        else if (idx[1:0] != 2'b0) fmt = FMT_TYPE1;
        else                       fmt = FMT_SLOT;
    end

    // Form the outgoing address for the chosen layout
    always_comb begin
        case (fmt)
            FMT_RAW:   addr = idx | {30'b0, off[1:0]};
            FMT_TYPE1: addr = {idx[31:3], off[2:0]};
            default:   addr = {1'b1, 15'b0, slot, idx[10:3], off[2:0]};
        endcase
    end

endmodule

// File: rtl/cfgx_irq_swizzle.sv
// Rotates a device's interrupt pin by its slot number onto one of
// NUM_LINES shared lines, and gives the controller input for that line.
module cfgx_irq_swizzle #(
    parameter int         NUM_LINES = 4,
    parameter logic [7:0] IRQ_BASE  = 8'h1B,
    localparam int        LW        = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic [7:0]    devfn,
    input  logic [LW-1:0] pin,
    output logic [LW-1:0] line,
    output logic [7:0]    vector
);

    // Line = (pin + slot) mod NUM_LINES; vector offsets from the base
    always_comb begin
        line   = LW'((32'(pin) + 32'(devfn[7:3])) % NUM_LINES);
        vector = IRQ_BASE + 8'(line);
    end

endmodule

// File: rtl/cfgx_translator.sv
// Top of the configuration address translator. Holds the index word,
// translates each data-window access into a registered request with a
// one-deep valid/ready output stage, and exposes the interrupt swizzle.
// Assumes the index write and data accesses come from the same clock.
module cfgx_translator
    import cfgx_pkg::*;
#(
    parameter int OFF_W   = 12,
    parameter int SLOT_LO = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 idx_wr,
    input  logic [CFG_AW-1:0]    idx_wdata,
    input  logic                 acc_valid,
    output logic                 acc_ready,
    input  logic                 acc_write,
    input  logic [OFF_W-1:0]     acc_offset,
    input  logic [1:0]           acc_size,
    output logic                 cfg_valid,
    input  logic                 cfg_ready,
    output logic [CFG_AW-1:0]    cfg_addr,
    output logic [CFG_BE_W-1:0]  cfg_be,
    output logic                 cfg_write,
    input  logic [7:0]           irq_devfn,
    input  logic [1:0]           irq_pin,
    output logic [1:0]           irq_line,
    output logic [7:0]           irq_vector
);

    logic [CFG_AW-1:0] idx_q;
    logic [CFG_AW-1:0] xl_addr;
    cfg_fmt_e          xl_fmt;
    logic              take;

    cfgx_addr_fmt #(.OFF_W(OFF_W), .SLOT_LO(SLOT_LO)) u_fmt (
        .idx  (idx_q),
        .off  (acc_offset),
        .addr (xl_addr),
        .fmt  (xl_fmt)
    );

    cfgx_irq_swizzle #(.NUM_LINES(4), .IRQ_BASE(8'h1B)) u_irq (
        .devfn  (irq_devfn),
        .pin    (irq_pin),
        .line   (irq_line),
        .vector (irq_vector)
    );

    // Output stage may accept when empty or being drained
    always_comb begin
        acc_ready = !cfg_valid || cfg_ready;
        take      = acc_valid && acc_ready;
    end

    // Index register: whole-word replace on write
    always_ff @(posedge clk) begin
        if (!rst_n)      idx_q <= '0;
        else if (idx_wr) idx_q <= idx_wdata;
    end

    // Output stage: load on accept, clear when drained
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_valid <= 1'b0;
            cfg_addr  <= '0;
            cfg_be    <= '0;
            cfg_write <= 1'b0;
        end else if (take) begin
            cfg_valid <= 1'b1;
            cfg_addr  <= xl_addr;
            cfg_be    <= lane_mask(acc_size, acc_offset[1:0]);
            cfg_write <= acc_write;
        end else if (cfg_ready) begin
            cfg_valid <= 1'b0;
        end
    end

    // Reset empties the output stage
    assert_reset_empty_R1: assert property (@(posedge clk)
        !rst_n |=> !cfg_valid);

    // Accepted access is presented next cycle with its direction
    assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> cfg_valid && (cfg_write == $past(acc_write)));

    // Stalled request holds steady
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && !cfg_ready |=> cfg_valid && $stable(cfg_addr)
                                    && $stable(cfg_be) && $stable(cfg_write));

    // A presented request always enables at least one lane
    assert_lanes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> cfg_be != '0);

    // Slot-layout requests always carry the enable bit and bus zero
    assert_slot_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take && xl_fmt == FMT_SLOT |=> cfg_addr[31] && cfg_addr[30:16] == '0);

endmodule

// File: tb/cfgx_translator_test.sv
module cfgx_translator_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        idx_wr;
    logic [31:0] idx_wdata;
    logic        acc_valid;
    logic        acc_ready;
    logic        acc_write;
    logic [11:0] acc_offset;
    logic [1:0]  acc_size;
    logic        cfg_valid;
    logic        cfg_ready;
    logic [31:0] cfg_addr;
    logic [3:0]  cfg_be;
    logic        cfg_write;
    logic [7:0]  irq_devfn;
    logic [1:0]  irq_pin;
    logic [1:0]  irq_line;
    logic [7:0]  irq_vector;

    int checks = 0;
    int errors = 0;
    logic [31:0] cur_idx;

    always #4 clk = ~clk;

    cfgx_translator uut (
        .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .idx_wdata(idx_wdata),
        .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_write(acc_write),
        .acc_offset(acc_offset), .acc_size(acc_size), .cfg_valid(cfg_valid),
        .cfg_ready(cfg_ready), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
        .cfg_write(cfg_write), .irq_devfn(irq_devfn), .irq_pin(irq_pin),
        .irq_line(irq_line), .irq_vector(irq_vector)
    );

    function automatic logic [31:0] exp_addr(logic [31:0] idx, logic [11:0] off);
        logic [4:0] slot;
        if (idx[31]) return idx | {30'b0, off[1:0]};
        if (idx[1:0] != 2'b00) return (idx & ~32'h7) | {29'b0, off[2:0]};
        slot = 5'd31;
        for (int i = 30; i >= 11; i--) if (idx[i]) slot = 5'(i);
        return 32'h8000_0000 | (32'(slot) << 11) | (idx & 32'h0000_07F8)
               | {29'b0, off[2:0]};
    endfunction

    function automatic logic [3:0] exp_be(logic [1:0] size, logic [1:0] lane);
        logic [7:0] m;
        m = (size == 2'd0) ? 8'h01 : (size == 2'd1) ? 8'h03 : 8'h0F;
        m = m << lane;
        return m[3:0];
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_idx(input logic [31:0] v);
        @(negedge clk);
        idx_wr = 1'b1; idx_wdata = v;
        @(negedge clk);
        idx_wr = 1'b0;
        cur_idx = v;
    endtask

    task automatic access(input logic [11:0] off, input logic [1:0] size,
                          input logic wr, input string req);
        logic [31:0] ea;
        @(negedge clk);
        acc_valid = 1'b1; acc_offset = off; acc_size = size; acc_write = wr;
        cfg_ready = 1'b1;
        ea = exp_addr(cur_idx, off);
        @(negedge clk);
        acc_valid = 1'b0;
        chk(cfg_valid == 1'b1, "R8 valid", 32'(cfg_valid), 32'd1);
        chk(cfg_write == wr, "R8 write", 32'(cfg_write), 32'(wr));
        chk(cfg_addr == ea, req, cfg_addr, ea);
        chk(cfg_be == exp_be(size, off[1:0]), "R7 be", 32'(cfg_be),
            32'(exp_be(size, off[1:0])));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20517));
        rst_n = 1'b0; idx_wr = 1'b0; idx_wdata = '0; acc_valid = 1'b0;
        acc_write = 1'b0; acc_offset = '0; acc_size = 2'd2; cfg_ready = 1'b1;
        irq_devfn = '0; irq_pin = '0; cur_idx = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(cfg_valid == 1'b0, "R1 valid", 32'(cfg_valid), 32'd0);
        rst_n = 1'b1;
        access(12'h000, 2'd2, 1'b0, "R1 index zero");
        chk(cfg_addr == 32'h8000_F800, "R1 addr", cfg_addr, 32'h8000_F800);

        // R2: top bit set, pass-through with low two offset bits
        write_idx(32'h8001_2344);
        access(12'h007, 2'd0, 1'b1, "R2 raw");
        chk(cfg_addr == 32'h8001_2347, "R2 raw or", cfg_addr, 32'h8001_2347);

        // R3: type-1 layout replaces bits 2:0
        write_idx(32'h0012_3A05);
        access(12'h002, 2'd1, 1'b0, "R3 type1");
        chk(cfg_addr == 32'h0012_3A02, "R3 replace", cfg_addr, 32'h0012_3A02);

        // R4: lowest of several select bits wins
        write_idx(32'h0401_1000 | 32'h0000_0520);
        access(12'h001, 2'd0, 1'b0, "R4 multi");
        chk(cfg_addr[15:11] == 5'd12, "R4 lowest", 32'(cfg_addr[15:11]), 32'd12);
        write_idx(32'h0000_0800);
        access(12'h000, 2'd2, 1'b0, "R4 bit11");
        chk(cfg_addr[15:11] == 5'd11, "R4 bit11 slot", 32'(cfg_addr[15:11]), 32'd11);

        // R5: no select bit gives slot 31
        write_idx(32'h0000_03FC);
        access(12'h006, 2'd1, 1'b1, "R5 none");
        chk(cfg_addr == 32'h8000_FBFE, "R5 slot31", cfg_addr, 32'h8000_FBFE);

        // R6: function and register fields
        write_idx(32'h4000_06A8);
        access(12'h003, 2'd0, 1'b0, "R6 fields");
        chk(cfg_addr == 32'h8000_F6AB, "R6 layout", cfg_addr, 32'h8000_F6AB);

        // R7: unaligned halfword and word truncate
        access(12'h003, 2'd1, 1'b0, "R7 half hi");
        chk(cfg_be == 4'b1000, "R7 half trunc", 32'(cfg_be), 32'h8);
        access(12'h002, 2'd3, 1'b0, "R7 size3");
        chk(cfg_be == 4'b1100, "R7 word trunc", 32'(cfg_be), 32'hC);

        // R9: backpressure holds the first request
        write_idx(32'h0000_2000);
        @(negedge clk);
        cfg_ready = 1'b0; acc_valid = 1'b1; acc_offset = 12'h004;
        acc_size = 2'd2; acc_write = 1'b1;
        @(negedge clk);
        acc_offset = 12'h001; acc_size = 2'd0; acc_write = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk(acc_ready == 1'b0, "R9 ready", 32'(acc_ready), 32'd0);
            chk(cfg_addr == 32'h8000_6804, "R9 hold", cfg_addr, 32'h8000_6804);
            chk(cfg_write == 1'b1, "R9 hold write", 32'(cfg_write), 32'd1);
        end
        cfg_ready = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0;
        chk(cfg_addr == 32'h8000_6801, "R9 next", cfg_addr, 32'h8000_6801);
        chk(cfg_be == 4'b0010, "R9 next be", 32'(cfg_be), 32'h2);
        @(negedge clk);
        chk(cfg_valid == 1'b0, "R8 drain", 32'(cfg_valid), 32'd0);

        // R12: random index words of every layout
        for (int n = 0; n < 300; n++) begin
            logic [31:0] v;
            int k;
            k = int'($urandom_range(0, 3));
            v = $urandom;
            case (k)
                0: v[31] = 1'b1;
                1: begin v[31] = 1'b0; if (v[1:0] == 2'b00) v[0] = 1'b1; end
                2: begin v[31] = 1'b0; v[1:0] = 2'b00; end
                default: begin
                    v = (32'h1 << $urandom_range(11, 30)) | ($urandom & 32'h7F8);
                end
            endcase
            write_idx(v);
            access(12'($urandom), 2'($urandom), 1'($urandom), "R12 random");
        end

        // R10 R11: interrupt swizzle sweep
        for (int s = 0; s < 32; s += 3) begin
            for (int p = 0; p < 4; p++) begin
                logic [1:0] el;
                @(negedge clk);
                irq_devfn = {5'(s), 3'($urandom)};
                irq_pin   = 2'(p);
                el = 2'((p + s) % 4);
                #1;
                chk(irq_line == el, "R10 line", 32'(irq_line), 32'(el));
                chk(irq_vector == 8'h1B + 8'(el), "R11 vector",
                    32'(irq_vector), 32'(8'h1B + 8'(el)));
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule